// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Target

This block is the target end of a three-wire control bus: an active-low frame enable, a serial clock driven by the host, and one data line that both sides share. It holds a bank of 24-bit configuration words. Downstream logic sees every word at once on a flat parallel bus. Each frame carries 32 bits, all least significant bit first. The first 7 bits are a word address. The next bit is a direction flag. The last 24 bits are data, which the host sends on a write and the target returns on a read. The host presents every incoming bit for a rising serial clock edge. On a read, the target changes the line after each falling edge, so the host can capture the bit on the next rising edge.

The three bus pins are sampled with the block's own system clock through two-stage synchronisers. Edges on the serial clock are found by comparing the synchronised level with its value one cycle earlier. The shared data line is brought out as three signals: an input, an output and an output enable. The pad driver sits outside the block. The serial clock must stay high for at least four system clocks and low for at least four system clocks.

A frame controller with six named states does the sequencing. IDLE waits for the enable. ADDR collects the address over rising edges 1 to 7. FLAG takes the direction bit on edge 8 and branches. If the flag is 1 it goes to WRITE, which collects data on edges 9 to 32 and commits the word. If the flag is 0 it goes to READ, which drives data out on the falls that follow edges 8 to 31. After edge 32 both paths enter DONE, which ignores any further serial clocks. A deasserted enable returns the controller from any state to IDLE. The transitions are IDLE→ADDR on the enable going low, ADDR→FLAG on the seventh rising edge, FLAG→WRITE or FLAG→READ on edge 8, WRITE→DONE and READ→DONE on edge 32, and any state→IDLE on the enable going high.

Top module: `tw_cfg_slave`

## Requirements
- R1: After reset, word i of the bank holds RST_BASE + i (default RST_BASE = 0x5A0000), and sdio_oe is low.
- R2: A frame starts while sen_n is low. The first seven rising serial clock edges carry the address, least significant bit first, so the bit on edge k is address bit k-1.
- R3: The bit on rising edge 8 selects the direction. A 1 means write and a 0 means read. A read frame leaves the bank unchanged.
- R4: In a write frame, rising edges 9 to 32 carry data bit 0 up to bit 23. The addressed word is replaced only after edge 32.
- R5: In a read frame, data bit j of the addressed word appears on sdio_out after the falling edge that follows rising edge 8+j. It stays there until the next rising edge.
- R6: sdio_oe is high only in the data phase of a read. That phase runs from the fall after edge 8 to the end of the frame. sdio_oe stays low during the address and flag bits and throughout write frames.
- R7: Raising sen_n before edge 32 abandons the frame. No word changes, sdio_oe goes low, and the next frame decodes normally.
- R8: For an address of N_REGS or above, a read returns all zeros with sdio_oe driven, and a write changes nothing.
- R9: cfg_flat bits [24i+23:24i] always show word i, and change only through a committed write.
- R10: Serial clock edges after edge 32 and before sen_n rises are ignored. They cause no second write, and sdio_oe goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| sen_n | input | 1 | Frame enable, active low |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Data line as seen from the pad |
| sdio_out | output | 1 | Read data bit to the pad driver |
| sdio_oe | output | 1 | Pad driver enable for the data line |
| cfg_flat | output | N_REGS*24 | All configuration words, word 0 in the low bits |

## Verification
A pin change reaches the synchronised level two system clocks later. The controller acts on the following edge, so a read bit appears on sdio_out three clocks after the serial clock falls. A committed word appears on cfg_flat about five clocks after the 32nd rising edge. The bench holds each serial clock phase for eight system clocks. It samples sdio_out and sdio_oe at the last falling system-clock edge before each serial rise, which is well after the bit is due. It checks cfg_flat and sdio_oe twelve clocks after sen_n rises, when every commit and release has settled. All sampling is done on falling system-clock edges, away from the edges the design registers on.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 24;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_FLAG,
        S_READ,
        S_WRITE,
        S_DONE
    } tw_state_e;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int            W       = 1,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= RST_VAL;
            q        <= RST_VAL;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/tw_regfile.sv
module tw_regfile #(
    parameter int              N_REGS   = 16,
    parameter int              AW       = 7,
    parameter int              DW       = 24,
    parameter logic [DW-1:0]   RST_BASE = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        addr,
    output logic [DW-1:0]        rd_word,
    input  logic                 wr_en,
    input  logic [DW-1:0]        wr_word,
    output logic [N_REGS*DW-1:0] cfg_flat
);
    logic [DW-1:0] regs [N_REGS];

    for (genvar i = 0; i < N_REGS; i++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[i] <= RST_BASE + DW'(i);
            else if (wr_en && addr == AW'(i))
                regs[i] <= wr_word;
        end
        assign cfg_flat[i*DW +: DW] = regs[i];
    end

    // Addresses with no word fall through to zero.
    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_REGS; i++)
            if (addr == AW'(i)) rd_word = regs[i];
    end

    // R8: a write to an address with no word leaves the bank untouched
    a_r8_unmapped_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(addr) >= N_REGS) |=> $stable(cfg_flat));

    // R9: the parallel view moves only after a write strobe
    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> $stable(cfg_flat));
endmodule

// File: rtl/tw_frame_fsm.sv
module tw_frame_fsm
    import tw_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_act,
    input  logic          sck_lvl,
    input  logic          din,
    input  logic [DW-1:0] rd_word,
    output logic [AW-1:0] addr_o,
    output logic          wr_en_o,
    output logic [DW-1:0] wr_word_o,
    output logic          dout_o,
    output logic          doe_o
);
    localparam int             CW     = $clog2(DW + 1);
    localparam logic [CW-1:0]  LAST_A = CW'(AW - 1);
    localparam logic [CW-1:0]  LAST_D = CW'(DW - 1);

    tw_state_e     state_q, state_d;
    logic          sck_q;
    logic          rise, fall;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] rd_sh_q;
    logic [DW-1:0] wr_sh_q;
    logic          wr_en_q;
    logic          dout_q;
    logic          doe_q;

    assign rise = sck_lvl & ~sck_q;
    assign fall = ~sck_lvl & sck_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!en_act) begin
            state_d = S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:  state_d = S_ADDR;
                S_ADDR:  if (rise && cnt_q == LAST_A) state_d = S_FLAG;
                S_FLAG:  if (rise) state_d = din ? S_WRITE : S_READ;
                S_READ:  if (rise && cnt_q == LAST_D) state_d = S_DONE;
                S_WRITE: if (rise && cnt_q == LAST_D) state_d = S_DONE;
                S_DONE:  state_d = S_DONE;
                default: state_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            sck_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            sck_q   <= sck_lvl;
        end
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            addr_q  <= '0;
            rd_sh_q <= '0;
            wr_sh_q <= '0;
            wr_en_q <= 1'b0;
            dout_q  <= 1'b0;
            doe_q   <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            if (!en_act) begin
                cnt_q  <= '0;
                dout_q <= 1'b0;
                doe_q  <= 1'b0;
            end else begin
                unique case (state_q)
                    S_IDLE: cnt_q <= '0;
                    S_ADDR: if (rise) begin
                        addr_q <= {din, addr_q[AW-1:1]};
                        cnt_q  <= (cnt_q == LAST_A) ? '0 : cnt_q + 1'b1;
                    end
                    S_FLAG: if (rise && !din) rd_sh_q <= rd_word;
                    S_READ: begin
                        if (fall) begin
                            dout_q  <= rd_sh_q[0];
                            rd_sh_q <= rd_sh_q >> 1;
                            doe_q   <= 1'b1;
                        end
                        if (rise) cnt_q <= cnt_q + 1'b1;
                    end
                    S_WRITE: if (rise) begin
                        wr_sh_q <= {din, wr_sh_q[DW-1:1]};
                        cnt_q   <= cnt_q + 1'b1;
                        if (cnt_q == LAST_D) wr_en_q <= 1'b1;
                    end
                    S_DONE: begin
                        cnt_q <= '0;
                        doe_q <= 1'b0;
                    end
                    default: cnt_q <= '0;
                endcase
            end
        end
    end

    assign addr_o    = addr_q;
    assign wr_en_o   = wr_en_q;
    assign wr_word_o = wr_sh_q;
    assign dout_o    = dout_q;
    assign doe_o     = doe_q;

    // R2: the address bit count never runs past the field width
    a_r2_addr_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ADDR) |-> (cnt_q < CW'(AW)));

    // R3: the flag edge always branches to one of the two data phases
    a_r3_flag_branch: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FLAG && rise && en_act) |=> (state_q == S_READ || state_q == S_WRITE));

    // R4: a commit strobe follows a rising serial edge in a write phase
    a_r4_commit_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($past(rise) && $past(state_q) == S_WRITE));

    // R6: the line is released once the enable drops
    a_r6_release_on_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_act) |=> !doe_o);

    // R6: the line is driven only around the read data phase
    a_r6_drive_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        doe_o |-> (state_q == S_READ || state_q == S_DONE || state_q == S_IDLE));
endmodule

// File: rtl/tw_cfg_slave.sv
module tw_cfg_slave
    import tw_pkg::*;
#(
    parameter int                N_REGS   = 16,
    parameter logic [DATA_W-1:0] RST_BASE = 24'h5A0000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sen_n,
    input  logic                     sclk,
    input  logic                     sdio_in,
    output logic                     sdio_out,
    output logic                     sdio_oe,
    output logic [N_REGS*DATA_W-1:0] cfg_flat
);
    logic              sen_s, sck_s, din_s;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] wr_word;
    logic              wr_en;

    tw_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sen_n, sclk, sdio_in}),
        .q     ({sen_s, sck_s, din_s})
    );

    tw_frame_fsm #(.AW(ADDR_W), .DW(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_act    (~sen_s),
        .sck_lvl   (sck_s),
        .din       (din_s),
        .rd_word   (rd_word),
        .addr_o    (addr),
        .wr_en_o   (wr_en),
        .wr_word_o (wr_word),
        .dout_o    (sdio_out),
        .doe_o     (sdio_oe)
    );

    tw_regfile #(
        .N_REGS   (N_REGS),
        .AW       (ADDR_W),
        .DW       (DATA_W),
        .RST_BASE (RST_BASE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .rd_word  (rd_word),
        .wr_en    (wr_en),
        .wr_word  (wr_word),
        .cfg_flat (cfg_flat)
    );
endmodule

// File: tb/tw_cfg_slave_tb_top.sv
module tw_cfg_slave_tb_top;
    localparam int          CLK_P = 10;
    localparam int          HALF  = 8;
    localparam int          N     = 16;
    localparam int          DW    = 24;
    localparam logic [23:0] BASE  = 24'h5A0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sen_n = 1'b1;
    logic sclk = 1'b0;
    logic sdio_in = 1'b0;
    logic sdio_out, sdio_oe;
    logic [N*DW-1:0] cfg_flat;

    int checks = 0;
    int errors = 0;
    logic [23:0] model [N];

    always #(CLK_P/2) clk = ~clk;

    tw_cfg_slave #(.N_REGS(N), .RST_BASE(BASE)) dut_i (
        .clk(clk), .rst_n(rst_n), .sen_n(sen_n), .sclk(sclk),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe), .cfg_flat(cfg_flat)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < N; i++)
            chk(cfg_flat[i*DW +: DW] == model[i], req, 32'(cfg_flat[i*DW +: DW]), 32'(model[i]));
    endtask

    // Host side of one frame. edges < 32 abandons the frame early.
    task automatic frame(input logic [6:0] a, input bit wr, input logic [23:0] wd,
                         input int edges, output logic [23:0] rd, output bit oe_bad);
        logic [31:0] bits;
        bits   = {wd, wr, a};
        rd     = '0;
        oe_bad = 1'b0;
        sen_n  = 1'b0;
        tick(HALF);
        for (int k = 1; k <= edges; k++) begin
            sdio_in = (k <= 32) ? bits[k-1] : 1'b1;
            tick(HALF);
            if (!wr && k >= 9 && k <= 32) begin
                rd[k-9] = sdio_out;
                if (!sdio_oe) oe_bad = 1'b1;
            end else if (sdio_oe) begin
                oe_bad = 1'b1;
            end
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
        tick(HALF);
        sen_n = 1'b1;
        tick(12);
    endtask

    function automatic logic [23:0] pat(input int i);
        return 24'(i * 24'h09A3C5 + 24'h00036F);
    endfunction

    initial begin
        logic [23:0] rd;
        bit          oe_bad;

        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset contents and idle driver
        for (int i = 0; i < N; i++) model[i] = BASE + 24'(i);
        check_bank("R1 reset value");
        chk(!sdio_oe, "R1 oe after reset", 32'(sdio_oe), 0);

        // R2 R4 R9: write every word, address field decoded LSB first
        for (int i = 0; i < N; i++) begin
            frame(7'(i), 1'b1, pat(i), 32, rd, oe_bad);
            model[i] = pat(i);
            chk(cfg_flat[i*DW +: DW] == model[i], "R4 write commit",
                32'(cfg_flat[i*DW +: DW]), 32'(model[i]));
            chk(!oe_bad, "R6 no drive in write frame", 32'(oe_bad), 0);
        end
        check_bank("R9 parallel view after writes");

        // R5 R6: read every word back
        for (int i = 0; i < N; i++) begin
            frame(7'(i), 1'b0, 24'hFFFFFF, 32, rd, oe_bad);
            chk(rd == model[i], "R5 read data", 32'(rd), 32'(model[i]));
            chk(!oe_bad, "R6 drive window in read", 32'(oe_bad), 0);
        end
        // R3: read frames changed nothing
        check_bank("R3 read leaves bank");

        // Boundary data patterns
        frame(7'd0, 1'b1, 24'hFFFFFF, 32, rd, oe_bad);  model[0]  = 24'hFFFFFF;
        frame(7'd15, 1'b1, 24'h000000, 32, rd, oe_bad); model[15] = 24'h000000;
        frame(7'd1, 1'b1, 24'h800001, 32, rd, oe_bad);  model[1]  = 24'h800001;
        check_bank("R4 boundary patterns");
        frame(7'd1, 1'b0, 24'h0, 32, rd, oe_bad);
        chk(rd == 24'h800001, "R5 end bits", 32'(rd), 32'h800001);

        // R8: unmapped addresses
        frame(7'd16, 1'b1, 24'h123456, 32, rd, oe_bad);
        frame(7'd64, 1'b1, 24'hABCDEF, 32, rd, oe_bad);
        frame(7'd127, 1'b1, 24'h777777, 32, rd, oe_bad);
        check_bank("R8 unmapped write");
        frame(7'd16, 1'b0, 24'h0, 32, rd, oe_bad);
        chk(rd == 24'h0, "R8 unmapped read zero", 32'(rd), 0);
        chk(!oe_bad, "R8 unmapped read drives", 32'(oe_bad), 0);
        frame(7'd127, 1'b0, 24'h0, 32, rd, oe_bad);
        chk(rd == 24'h0, "R8 top address read zero", 32'(rd), 0);

        // R7: abandoned frames
        frame(7'd3, 1'b1, 24'h0BAD00, 31, rd, oe_bad);
        check_bank("R7 abandoned write");
        chk(!sdio_oe, "R7 oe after abort", 32'(sdio_oe), 0);
        frame(7'd5, 1'b0, 24'h0, 20, rd, oe_bad);
        chk(rd[10:0] == model[5][10:0], "R7 partial read", 32'(rd[10:0]), 32'(model[5][10:0]));
        chk(!sdio_oe, "R7 oe after read abort", 32'(sdio_oe), 0);
        frame(7'd3, 1'b1, 24'h3C3C3C, 32, rd, oe_bad);
        model[3] = 24'h3C3C3C;
        check_bank("R7 next frame decodes");

        // R10: extra edges after the data phase
        frame(7'd7, 1'b1, 24'h5AA5C3, 36, rd, oe_bad);
        model[7] = 24'h5AA5C3;
        check_bank("R10 extra edges on write");
        frame(7'd7, 1'b0, 24'h0, 36, rd, oe_bad);
        chk(rd == model[7], "R10 read with extra edges", 32'(rd), 32'(model[7]));
        chk(!oe_bad, "R10 oe released after edge 32", 32'(oe_bad), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule